// File: doc/BRIEF.md
# Wiper Position Counter with Tap Select Decoder

This block keeps the volatile wiper position of one digitally controlled potentiometer and turns it into a one-hot select for the switch array. The switches sit at both ends of the resistor string and between every pair of its segments. A command decoder that sits outside this block drives the position through three paths:

- a direct serial write of a new value;
- a parallel copy from one of the pot's stored data registers, either for this pot alone or as part of a transfer that loads every pot at once;
- single steps while an increment/decrement command is open.

Stepping counts up or down and stops at the ends. It never wraps.

After reset the block waits for a supplies-stable indication. It then copies stored data register 0 into the position exactly once, and ignores every other request until that copy is done. The current position is driven out so the command decoder can read it back. A chip with two pots uses two instances.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `pos` is 0 and `tap_sel` has only bit 0 set, until the power-up recall happens.
- R2: While the recall is pending and `supply_ok` is low, transfer, serial write and step requests are ignored: `pos` stays 0.
- R3: At the first clock edge where `supply_ok` is high and the recall is pending, `pos` takes data register 0, which is `bank_data[5:0]`. The recall happens once only: later changes to register 0 leave `pos` alone.
- R4: `tap_sel` has exactly one bit set, and that bit's index equals `pos`. Position 0 selects bit 0, the low-terminal tap. Position 63 selects bit 63, the high-terminal tap.
- R5: `xfer_req` or `glb_xfer_req` loads data register k, which is `bank_data[6k+5:6k]` with k given by `xfer_sel`, at the next edge.
- R6: `ser_wr` loads `ser_data` into `pos` at the next edge.
- R7: With `step_mode` high, each cycle with `step_pulse` high moves `pos` by one at the next edge: up when `step_up` is 1, down when it is 0.
- R8: A step up at 63 and a step down at 0 leave `pos` unchanged. The counter does not wrap.
- R9: Priority is recall, then transfer (either kind), then serial write, then step. In a cycle with several requests only the highest one takes effect.
- R10: `step_pulse` while `step_mode` is low leaves `pos` unchanged, and so does a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supplies stable; allows the power-up recall |
| bank_data | input | NUM_BANKS*POS_W | Stored data registers, register k in bits [POS_W*k+POS_W-1 : POS_W*k] |
| xfer_req | input | 1 | Copy the selected data register to this pot |
| glb_xfer_req | input | 1 | Transfer that loads all pots at once; same effect here |
| xfer_sel | input | $clog2(NUM_BANKS) | Index of the data register to copy |
| ser_wr | input | 1 | Serial write strobe |
| ser_data | input | POS_W | Serial write value |
| step_mode | input | 1 | Increment/decrement command is open |
| step_pulse | input | 1 | One-cycle strobe for each clock-high pulse of the serial clock |
| step_up | input | 1 | Step direction, 1 = toward the high terminal |
| pos | output | POS_W | Current wiper position |
| tap_sel | output | 2**POS_W | One-hot switch select |

## Verification
Serial writes of 0, 63 and a mid value tell apart the two end taps and an interior line of the decoder. Transfers from each of the four registers, with distinct values in each, expose a wrong slice or a wrong select. Step runs in both directions, with idle cycles in between, separate per-pulse stepping from level-driven stepping. Runs that start next to the ends show whether the counter saturates or wraps. Requests placed together in one cycle, together with requests issued before and after the supplies-stable indication, pin down the priority order and the once-only recall.

// File: rtl/wtap_pkg.sv
package wtap_pkg;

   // Which source updates the wiper position at the next edge
   typedef enum logic [2:0] {
      SRC_KEEP   = 3'd0,
      SRC_RECALL = 3'd1,
      SRC_XFER   = 3'd2,
      SRC_SERIAL = 3'd3,
      SRC_STEP   = 3'd4
   } wtap_src_e;

endpackage

// File: rtl/wtap_arbiter.sv
module wtap_arbiter
   import wtap_pkg::*;
(
   input  logic      recall_pending,
   input  logic      supply_ok,
   input  logic      xfer_any,
   input  logic      ser_wr,
   input  logic      step_fire,
   output wtap_src_e src
);

   // Fixed priority: recall, transfer, serial write, step
   always_comb begin
      src = SRC_KEEP;
      if (recall_pending) begin
         if (supply_ok) src = SRC_RECALL;
      end else if (xfer_any) begin
         src = SRC_XFER;
      end else if (ser_wr) begin
         src = SRC_SERIAL;
      end else if (step_fire) begin
         src = SRC_STEP;
      end
   end

endmodule

// File: rtl/wtap_stepper.sv
module wtap_stepper #(
   parameter int POS_W = 6
) (
   input  logic [POS_W-1:0] pos_q,
   input  logic             up,
   output logic [POS_W-1:0] pos_step
);

   localparam logic [POS_W-1:0] TOP_V = {POS_W{1'b1}};
   localparam logic [POS_W-1:0] BOT_V = '0;
   localparam logic [POS_W-1:0] ONE_V = POS_W'(1);

   logic at_top;
   logic at_bot;

   assign at_top = (pos_q == TOP_V);
   assign at_bot = (pos_q == BOT_V);

   // Saturating single step
   always_comb begin
      pos_step = pos_q;
      if (up && !at_top)       pos_step = pos_q + ONE_V;
      else if (!up && !at_bot) pos_step = pos_q - ONE_V;
   end

endmodule

// File: rtl/wtap_bank_mux.sv
module wtap_bank_mux #(
   parameter int POS_W     = 6,
   parameter int NUM_BANKS = 4,
   localparam int SEL_W    = $clog2(NUM_BANKS)
) (
   input  logic [NUM_BANKS*POS_W-1:0] bank_flat,
   input  logic [SEL_W-1:0]           sel,
   output logic [POS_W-1:0]           bank_q,
   output logic [POS_W-1:0]           bank0_q
);

   logic [POS_W-1:0] bank_arr [NUM_BANKS];

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_unpack
      assign bank_arr[k] = bank_flat[k*POS_W +: POS_W];
   end

   always_comb begin
      bank_q = bank_arr[0];
      for (int k = 0; k < NUM_BANKS; k++) begin
         if (sel == SEL_W'(k)) bank_q = bank_arr[k];
      end
   end

   assign bank0_q = bank_arr[0];

endmodule

// File: rtl/wtap_decode.sv
module wtap_decode #(
   parameter int POS_W        = 6,
   parameter int DECODE_STYLE = 0,
   localparam int TAPS        = 1 << POS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [POS_W-1:0] pos,
   output logic [TAPS-1:0]  tap_sel
);

   if (DECODE_STYLE == 0) begin : g_cmp
      // One comparator per switch line
      for (genvar i = 0; i < TAPS; i++) begin : g_line
         assign tap_sel[i] = (pos == POS_W'(i));
      end
   end else begin : g_shift
      // Barrel shift of a single set bit
      assign tap_sel = TAPS'(1) << pos;
   end

   AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(tap_sel) == 1) && tap_sel[pos]); // R4

endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl
   import wtap_pkg::*;
#(
   parameter int POS_W        = 6,
   parameter int NUM_BANKS    = 4,
   parameter int DECODE_STYLE = 0,
   localparam int SEL_W       = $clog2(NUM_BANKS),
   localparam int TAPS        = 1 << POS_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       supply_ok,
   input  logic [NUM_BANKS*POS_W-1:0] bank_data,
   input  logic                       xfer_req,
   input  logic                       glb_xfer_req,
   input  logic [SEL_W-1:0]           xfer_sel,
   input  logic                       ser_wr,
   input  logic [POS_W-1:0]           ser_data,
   input  logic                       step_mode,
   input  logic                       step_pulse,
   input  logic                       step_up,
   output logic [POS_W-1:0]           pos,
   output logic [TAPS-1:0]            tap_sel
);

   localparam logic [POS_W-1:0] TOP_V = {POS_W{1'b1}};

   // Parameter checks at elaboration
   if (POS_W < 2 || POS_W > 10) begin : g_bad_width
      $error("wiper_tap_ctrl: POS_W out of range");
   end
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("wiper_tap_ctrl: NUM_BANKS must be at least 2");
   end
   if (DECODE_STYLE != 0 && DECODE_STYLE != 1) begin : g_bad_style
      $error("wiper_tap_ctrl: DECODE_STYLE must be 0 or 1");
   end

   logic             recall_pending_q;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] pos_d;
   logic [POS_W-1:0] pos_step;
   logic [POS_W-1:0] bank_sel_q;
   logic [POS_W-1:0] bank0_q;
   logic             xfer_any;
   logic             step_fire;
   wtap_src_e        src;

   assign xfer_any  = xfer_req | glb_xfer_req;
   assign step_fire = step_mode & step_pulse;

   wtap_arbiter u_arb (
      .recall_pending (recall_pending_q),
      .supply_ok      (supply_ok),
      .xfer_any       (xfer_any),
      .ser_wr         (ser_wr),
      .step_fire      (step_fire),
      .src            (src)
   );

   wtap_bank_mux #(.POS_W(POS_W), .NUM_BANKS(NUM_BANKS)) u_mux (
      .bank_flat (bank_data),
      .sel       (xfer_sel),
      .bank_q    (bank_sel_q),
      .bank0_q   (bank0_q)
   );

   wtap_stepper #(.POS_W(POS_W)) u_step (
      .pos_q    (pos_q),
      .up       (step_up),
      .pos_step (pos_step)
   );

   always_comb begin
      unique case (src)
         SRC_RECALL: pos_d = bank0_q;
         SRC_XFER:   pos_d = bank_sel_q;
         SRC_SERIAL: pos_d = ser_data;
         SRC_STEP:   pos_d = pos_step;
         default:    pos_d = pos_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q            <= '0;
         recall_pending_q <= 1'b1;
      end else begin
         pos_q <= pos_d;
         if (supply_ok) recall_pending_q <= 1'b0;
      end
   end

   wtap_decode #(.POS_W(POS_W), .DECODE_STYLE(DECODE_STYLE)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .pos     (pos_q),
      .tap_sel (tap_sel)
   );

   assign pos = pos_q;

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      recall_pending_q && !supply_ok |=> $stable(pos_q)); // R2
   AST_RECALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      recall_pending_q && supply_ok |=> pos_q == $past(bank_data[POS_W-1:0])); // R3
   AST_RECALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      !recall_pending_q |=> !recall_pending_q); // R3
   AST_XFER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      !recall_pending_q && xfer_any |=> pos_q == $past(bank_sel_q)); // R9
   AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !recall_pending_q && !xfer_any && ser_wr |=> pos_q == $past(ser_data)); // R6
   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      !recall_pending_q && !xfer_any && !ser_wr && step_fire && step_up && pos_q != TOP_V
      |=> pos_q == POS_W'($past(pos_q) + POS_W'(1))); // R7
   AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      !recall_pending_q && !xfer_any && !ser_wr && step_fire && step_up && pos_q == TOP_V
      |=> pos_q == TOP_V); // R8
   AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
      !recall_pending_q && !xfer_any && !ser_wr && step_fire && !step_up && pos_q == '0
      |=> pos_q == '0); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !recall_pending_q && !xfer_any && !ser_wr && !step_fire |=> $stable(pos_q)); // R10

endmodule

// File: tb/wiper_tap_ctrl_bench.sv
module wiper_tap_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        supply_ok = 1'b0;
   logic [23:0] bank_data = '0;
   logic        xfer_req = 1'b0;
   logic        glb_xfer_req = 1'b0;
   logic [1:0]  xfer_sel = '0;
   logic        ser_wr = 1'b0;
   logic [5:0]  ser_data = '0;
   logic        step_mode = 1'b0;
   logic        step_pulse = 1'b0;
   logic        step_up = 1'b0;
   logic [5:0]  pos;
   logic [63:0] tap_sel;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   wiper_tap_ctrl u_wiper_tap_ctrl (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .bank_data(bank_data),
      .xfer_req(xfer_req), .glb_xfer_req(glb_xfer_req), .xfer_sel(xfer_sel),
      .ser_wr(ser_wr), .ser_data(ser_data), .step_mode(step_mode),
      .step_pulse(step_pulse), .step_up(step_up), .pos(pos), .tap_sel(tap_sel)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_tap(input string req, input int v);
      chk(req, $countones(tap_sel), 1);
      chk(req, int'(tap_sel[v]), 1);
   endtask

   task automatic ser_write(input logic [5:0] v);
      ser_wr = 1'b1; ser_data = v;
      tick();
      ser_wr = 1'b0;
   endtask

   task automatic one_step(input logic up);
      step_up = up; step_pulse = 1'b1;
      tick();
      step_pulse = 1'b0;
      tick();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tick();
      chk("R1 pos in reset", pos, 0);
      chk_tap("R1 tap in reset", 0);
      rst_n = 1'b1;
      tick();
      chk("R1 pos after release", pos, 0);
   endtask

   task automatic t_holdoff();
      bank_data = {6'd9, 6'd50, 6'd17, 6'd42};
      ser_write(6'd11);
      chk("R2 serial ignored before recall", pos, 0);
      xfer_req = 1'b1; xfer_sel = 2'd2;
      tick();
      xfer_req = 1'b0;
      chk("R2 transfer ignored before recall", pos, 0);
      step_mode = 1'b1;
      one_step(1'b1);
      step_mode = 1'b0;
      chk("R2 step ignored before recall", pos, 0);
      // recall together with a serial write: the recall wins (R9)
      supply_ok = 1'b1; ser_wr = 1'b1; ser_data = 6'd5;
      tick();
      ser_wr = 1'b0;
      chk("R3 recall of register 0", pos, 42);
      chk_tap("R3 tap after recall", 42);
      bank_data[5:0] = 6'd7;
      tick(); tick();
      chk("R3 recall happens once", pos, 42);
   endtask

   task automatic t_serial();
      ser_write(6'd0);
      chk("R6 serial write 0", pos, 0);
      chk_tap("R4 low terminal tap", 0);
      ser_write(6'd63);
      chk("R6 serial write 63", pos, 63);
      chk_tap("R4 high terminal tap", 63);
      ser_write(6'd21);
      chk("R6 serial write 21", pos, 21);
      chk_tap("R4 mid tap", 21);
   endtask

   task automatic t_xfer();
      bank_data = {6'd33, 6'd12, 6'd58, 6'd3};
      for (int k = 0; k < 4; k++) begin
         xfer_req = 1'b1; xfer_sel = 2'(k);
         tick();
         xfer_req = 1'b0;
         chk($sformatf("R5 local transfer reg %0d", k), pos, int'(bank_data[k*6 +: 6]));
      end
      glb_xfer_req = 1'b1; xfer_sel = 2'd1;
      tick();
      glb_xfer_req = 1'b0;
      chk("R5 global transfer reg 1", pos, 58);
   endtask

   task automatic t_step();
      ser_write(6'd30);
      step_mode = 1'b1;
      for (int i = 0; i < 3; i++) one_step(1'b1);
      chk("R7 three steps up", pos, 33);
      for (int i = 0; i < 5; i++) one_step(1'b0);
      chk("R7 five steps down", pos, 28);
      step_up = 1'b1; step_pulse = 1'b1;
      tick(); tick();
      step_pulse = 1'b0;
      chk("R7 two back-to-back pulses", pos, 30);
      step_mode = 1'b0;
      one_step(1'b1);
      chk("R10 pulse without step mode", pos, 30);
      tick(); tick();
      chk("R10 idle holds", pos, 30);
   endtask

   task automatic t_saturate();
      step_mode = 1'b1;
      ser_write(6'd62);
      for (int i = 0; i < 3; i++) one_step(1'b1);
      chk("R8 saturate at 63", pos, 63);
      chk_tap("R8 tap at top", 63);
      ser_write(6'd1);
      for (int i = 0; i < 3; i++) one_step(1'b0);
      chk("R8 saturate at 0", pos, 0);
      step_mode = 1'b0;
   endtask

   task automatic t_priority();
      bank_data = {6'd44, 6'd25, 6'd36, 6'd19};
      xfer_req = 1'b1; xfer_sel = 2'd3; ser_wr = 1'b1; ser_data = 6'd8;
      tick();
      xfer_req = 1'b0; ser_wr = 1'b0;
      chk("R9 transfer over serial", pos, 44);
      step_mode = 1'b1; step_pulse = 1'b1; step_up = 1'b1;
      ser_wr = 1'b1; ser_data = 6'd10;
      tick();
      ser_wr = 1'b0; step_pulse = 1'b0;
      chk("R9 serial over step", pos, 10);
      step_pulse = 1'b1; step_up = 1'b0;
      glb_xfer_req = 1'b1; xfer_sel = 2'd0;
      tick();
      glb_xfer_req = 1'b0; step_pulse = 1'b0; step_mode = 1'b0;
      chk("R9 transfer over step", pos, 19);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_holdoff();
      t_serial();
      t_xfer();
      t_step();
      t_saturate();
      t_priority();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule